// File: doc/BRIEF.md
# Partitioned Associative Memory Array

This block is a small content-addressable store of wide entries. Every entry is split into a searched part and an unsearched part. The split is set at run time in whole 16-bit segments, starting from the least significant segment. The searched part holds the key. The unsearched part carries data that travels with the key but never affects a search. Each entry also carries a two-bit class: valid, empty, skip or data-only.

A search strobe compares a comparand against the searched part of every entry of one chosen class. An optional global bit mask turns selected comparand bits into don't-care positions. The outcome is held in registers until the next strobe: a hit flag and the lowest-numbered hit address. Separately, the block keeps a registered lowest empty address and a full flag. Writes store a data word and a class, and reach their entry in one of three ways: by an absolute address, at the last hit address, or at the lowest empty address. A read returns an entry's data together with its class.

Top module: `pcam_core`

## Requirements
- R1: While reset is asserted, every entry becomes empty with zero data, and the hit flag, hit address, full flag and free address are all cleared to zero.
- R2: A read of address A returns the entry's 64-bit data and its 2-bit class on the outputs one cycle after the read strobe. The class encoding is {skip, empty}: 00 valid, 01 empty, 10 skip, 11 data-only.
- R3: A search strobe registers the hit flag and hit address one cycle later. When several entries hit, the lowest address is reported.
- R4: The configuration value N (0 to 3) makes the lowest N+1 16-bit segments searchable. Bits above those segments never affect a search.
- R5: When mask enable is 1, comparand bits whose mask bit is 1 are don't-care. When mask enable is 0, the mask has no effect.
- R6: Only entries whose class equals the search class (same encoding as R2) can hit; entries of any other class are never reported.
- R7: When no entry hits, the hit flag is 0 and the hit address is 0.
- R8: The write mode selects the target entry: 00 writes at an absolute address, 01 at the registered hit address, 10 at the registered free address, and 11 writes nothing. A mode-01 write while the hit flag is 0 changes no entry, and neither does a mode-10 write while the full flag is 1.
- R9: One cycle after any change to the classes, the free address shows the lowest-numbered empty entry. When no entry is empty, the full flag is 1 and the free address is 0.
- R10: The hit flag and hit address keep their values on every cycle that follows a cycle without a search strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cam_segs | input | 2 | Number of searchable segments minus one |
| cmp_strobe | input | 1 | Start a search |
| cmp_type | input | 2 | Entry class to search |
| cmp_data | input | 64 | Comparand |
| cmp_mask | input | 64 | Don't-care bits (1 = ignore) |
| cmp_mask_en | input | 1 | Apply cmp_mask |
| wr_en | input | 1 | Write strobe |
| wr_mode | input | 2 | Write target selection |
| wr_addr | input | 4 | Absolute write address |
| wr_data | input | 64 | Write data |
| wr_type | input | 2 | Class stored with the write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 64 | Registered read data |
| rd_type | output | 2 | Registered class of the entry read |
| match_flag | output | 1 | Last search found a hit |
| match_addr | output | 4 | Lowest hitting address |
| free_addr | output | 4 | Lowest empty address |
| full_flag | output | 1 | No empty entry |

## Verification
The searches run against a preloaded array that holds duplicate keys, keys that share their low segments, and entries of every class. Duplicate keys separate lowest-address priority from any other ordering. Keys that differ only in high segments show whether the segment split truncates the compare at the right boundary. Running the same key against different classes shows whether the class filter is applied. Masked and unmasked searches with one comparand show whether the enable gates the mask. Writes by hit address after a failed search, and by free address on a full array, are followed by reads of the entries such a write could have reached.

// File: rtl/pcam_pkg.sv
package pcam_pkg;
   typedef enum logic [1:0] {
      ET_VALID = 2'b00,
      ET_EMPTY = 2'b01,
      ET_SKIP  = 2'b10,
      ET_RAM   = 2'b11
   } etype_t;

   typedef enum logic [1:0] {
      WM_ABS   = 2'b00,
      WM_MATCH = 2'b01,
      WM_FREE  = 2'b10,
      WM_NONE  = 2'b11
   } wmode_t;
endpackage

// File: rtl/pcam_seg_care.sv
module pcam_seg_care #(
   parameter int DATA_W = 64,
   parameter int SEG_W  = 16,
   localparam int NSEG  = DATA_W / SEG_W,
   localparam int SW    = $clog2(NSEG)
) (
   input  logic [SW-1:0]     cam_segs,
   input  logic [DATA_W-1:0] mask,
   input  logic              mask_en,
   output logic [DATA_W-1:0] care
);
   logic [DATA_W-1:0] seg_care;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      assign seg_care[s*SEG_W +: SEG_W] = (SW'(s) <= cam_segs) ? {SEG_W{1'b1}} : {SEG_W{1'b0}};
   end

   assign care = mask_en ? (seg_care & ~mask) : seg_care;
endmodule

// File: rtl/pcam_match_line.sv
module pcam_match_line
   import pcam_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] entry_data,
   input  etype_t            entry_type,
   input  logic [DATA_W-1:0] key,
   input  logic [1:0]        key_type,
   input  logic [DATA_W-1:0] care,
   output logic              hit
);
   assign hit = (entry_type == etype_t'(key_type)) && (((entry_data ^ key) & care) == '0);
endmodule

// File: rtl/pcam_prio_enc.sv
module pcam_prio_enc #(
   parameter int N  = 16,
   localparam int AW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [AW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = AW'(i);
      end
   end
endmodule

// File: rtl/pcam_core.sv
module pcam_core
   import pcam_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 64,
   parameter int SEG_W  = 16,
   localparam int NSEG  = DATA_W / SEG_W,
   localparam int SW    = $clog2(NSEG),
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SW-1:0]     cfg_cam_segs,
   input  logic              cmp_strobe,
   input  logic [1:0]        cmp_type,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic [DATA_W-1:0] cmp_mask,
   input  logic              cmp_mask_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_mode,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        wr_type,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_type,
   output logic              match_flag,
   output logic [AW-1:0]     match_addr,
   output logic [AW-1:0]     free_addr,
   output logic              full_flag
);
   if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
      $error("pcam_core: DEPTH must be a power of two of at least 2");
   end
   if (NSEG < 2 || DATA_W != NSEG * SEG_W) begin : g_bad_width
      $error("pcam_core: DATA_W must be at least two whole segments");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   etype_t            typ [DEPTH];
   logic [DATA_W-1:0] care;
   logic [DEPTH-1:0]  hit_vec;
   logic [DEPTH-1:0]  empty_vec;
   logic              hit_any, free_any;
   logic [AW-1:0]     hit_idx, free_idx;
   logic              wr_go;
   logic [AW-1:0]     wr_sel;

   pcam_seg_care #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_care (
      .cam_segs (cfg_cam_segs),
      .mask     (cmp_mask),
      .mask_en  (cmp_mask_en),
      .care     (care)
   );

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      pcam_match_line #(.DATA_W(DATA_W)) u_ml (
         .entry_data (mem[e]),
         .entry_type (typ[e]),
         .key        (cmp_data),
         .key_type   (cmp_type),
         .care       (care),
         .hit        (hit_vec[e])
      );
      assign empty_vec[e] = (typ[e] == ET_EMPTY);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mem[e] <= '0;
            typ[e] <= ET_EMPTY;
         end else if (wr_go && wr_sel == AW'(e)) begin
            mem[e] <= wr_data;
            typ[e] <= etype_t'(wr_type);
         end
      end
   end

   pcam_prio_enc #(.N(DEPTH)) u_hit_enc (
      .req (hit_vec),
      .any (hit_any),
      .idx (hit_idx)
   );

   pcam_prio_enc #(.N(DEPTH)) u_free_enc (
      .req (empty_vec),
      .any (free_any),
      .idx (free_idx)
   );

   always_comb begin
      wr_go  = 1'b0;
      wr_sel = wr_addr;
      case (wmode_t'(wr_mode))
         WM_ABS: begin
            wr_go  = wr_en;
            wr_sel = wr_addr;
         end
         WM_MATCH: begin
            wr_go  = wr_en && match_flag;
            wr_sel = match_addr;
         end
         WM_FREE: begin
            wr_go  = wr_en && !full_flag;
            wr_sel = free_addr;
         end
         default: wr_go = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_flag <= 1'b0;
         match_addr <= '0;
         free_addr  <= '0;
         full_flag  <= 1'b0;
         rd_data    <= '0;
         rd_type    <= 2'b00;
      end else begin
         if (cmp_strobe) begin
            match_flag <= hit_any;
            match_addr <= hit_any ? hit_idx : '0;
         end
         free_addr <= free_any ? free_idx : '0;
         full_flag <= !free_any;
         if (rd_en) begin
            rd_data <= mem[rd_addr];
            rd_type <= typ[rd_addr];
         end
      end
   end
endmodule

// File: rtl/pcam_core_chk.sv
module pcam_core_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmp_strobe,
   input logic          match_flag,
   input logic [AW-1:0] match_addr,
   input logic [AW-1:0] free_addr,
   input logic          full_flag
);
   AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (!match_flag && !full_flag && match_addr == '0)) else $error("reset state"); // R1
   AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(match_flag) |-> $past(cmp_strobe)) else $error("hit without strobe"); // R3
   AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !match_flag |-> match_addr == '0) else $error("miss address"); // R7
   AST_FULL_FREE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) full_flag |-> free_addr == '0) else $error("full free address"); // R9
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(cmp_strobe) |-> ($stable(match_flag) && $stable(match_addr))) else $error("result moved"); // R10
endmodule

bind pcam_core pcam_core_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmp_strobe (cmp_strobe),
   .match_flag (match_flag),
   .match_addr (match_addr),
   .free_addr  (free_addr),
   .full_flag  (full_flag)
);

// File: tb/pcam_core_tb.sv
`timescale 1ns/1ps
module pcam_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_cam_segs = '0;
   logic        cmp_strobe = 1'b0;
   logic [1:0]  cmp_type = '0;
   logic [63:0] cmp_data = '0;
   logic [63:0] cmp_mask = '0;
   logic        cmp_mask_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_mode = '0;
   logic [3:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [1:0]  wr_type = '0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_addr = '0;
   logic [63:0] rd_data;
   logic [1:0]  rd_type;
   logic        match_flag;
   logic [3:0]  match_addr;
   logic [3:0]  free_addr;
   logic        full_flag;

   int checks = 0;
   int failures = 0;

   localparam logic [63:0] KA = 64'h1111_2222_3333_4444;
   localparam logic [63:0] KB = 64'hAAAA_BBBB_CCCC_4444;
   localparam logic [63:0] KC = 64'h0000_0000_0000_5555;
   localparam logic [63:0] KD = 64'h0D0D_0D0D_0D0D_0D0D;
   localparam logic [63:0] KE = 64'h0E0E_0E0E_0E0E_0E0E;
   localparam logic [63:0] KF = 64'hF0F0_F0F0_F0F0_F0F0;

   typedef struct packed {
      logic [3:0]  req;
      logic [1:0]  segs;
      logic [1:0]  ctype;
      logic        men;
      logic [63:0] mask;
      logic [63:0] data;
      logic        eflag;
      logic [3:0]  eaddr;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{4'd3,  2'd3, 2'b00, 1'b0, 64'h0, KA, 1'b1, 4'd0},                                         // R3 duplicate key, lowest wins
      '{4'd3,  2'd3, 2'b00, 1'b0, 64'h0, KB, 1'b1, 4'd1},                                         // R3
      '{4'd4,  2'd0, 2'b00, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_4444, 1'b1, 4'd0},                    // R4 one segment
      '{4'd7,  2'd3, 2'b00, 1'b0, 64'h0, 64'h1111_2222_3333_4445, 1'b0, 4'd0},                    // R7 miss
      '{4'd6,  2'd3, 2'b10, 1'b0, 64'h0, KA, 1'b1, 4'd2},                                         // R6 skip class
      '{4'd6,  2'd3, 2'b11, 1'b0, 64'h0, KC, 1'b1, 4'd4},                                         // R6 data-only class
      '{4'd5,  2'd3, 2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_0000, 64'h9999_9999_9999_4444, 1'b1, 4'd0},  // R5 masked
      '{4'd5,  2'd3, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_0000, 64'h9999_9999_9999_4444, 1'b0, 4'd0},  // R5 mask disabled
      '{4'd4,  2'd1, 2'b00, 1'b0, 64'h0, 64'h0000_0000_CCCC_4444, 1'b1, 4'd1},                    // R4 two segments
      '{4'd6,  2'd0, 2'b01, 1'b0, 64'h0, 64'h0, 1'b1, 4'd5},                                      // R6 empty class
      '{4'd6,  2'd3, 2'b11, 1'b0, 64'h0, KA, 1'b0, 4'd0}                                          // R6 key of other class
   };

   pcam_core u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_cam_segs(cfg_cam_segs),
      .cmp_strobe(cmp_strobe), .cmp_type(cmp_type), .cmp_data(cmp_data),
      .cmp_mask(cmp_mask), .cmp_mask_en(cmp_mask_en),
      .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data), .wr_type(wr_type),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_type(rd_type),
      .match_flag(match_flag), .match_addr(match_addr), .free_addr(free_addr), .full_flag(full_flag)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [1:0] mode, input logic [3:0] addr, input logic [63:0] data, input logic [1:0] ty);
      wr_en = 1'b1; wr_mode = mode; wr_addr = addr; wr_data = data; wr_type = ty;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_rd(input logic [3:0] addr);
      rd_en = 1'b1; rd_addr = addr;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic do_cmp(input logic [1:0] segs, input logic [1:0] ty, input logic men,
                         input logic [63:0] mask, input logic [63:0] data);
      cfg_cam_segs = segs; cmp_type = ty; cmp_mask_en = men; cmp_mask = mask; cmp_data = data;
      cmp_strobe = 1'b1;
      @(negedge clk);
      cmp_strobe = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 match_flag", 64'(match_flag), 64'd0);
      chk("R1 full_flag", 64'(full_flag), 64'd0);
      chk("R1 free_addr", 64'(free_addr), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      do_rd(4'd3);
      chk("R1 entry class empty", 64'(rd_type), 64'd1);
      chk("R1 entry data zero", rd_data, 64'd0);

      do_wr(2'b00, 4'd0, KA, 2'b00);
      do_wr(2'b00, 4'd1, KB, 2'b00);
      do_wr(2'b00, 4'd2, KA, 2'b10);
      do_wr(2'b00, 4'd3, KA, 2'b00);
      do_wr(2'b00, 4'd4, KC, 2'b11);
      chk("R9 free after preload", 64'(free_addr), 64'd5);
      chk("R9 not full", 64'(full_flag), 64'd0);

      do_rd(4'd1);
      chk("R2 read data", rd_data, KB);
      chk("R2 read class valid", 64'(rd_type), 64'd0);
      do_rd(4'd4);
      chk("R2 read data-only entry", rd_data, KC);
      chk("R2 read class data-only", 64'(rd_type), 64'd3);

      for (int i = 0; i < NV; i++) begin
         do_cmp(VECS[i].segs, VECS[i].ctype, VECS[i].men, VECS[i].mask, VECS[i].data);
         checks++;
         if (match_flag !== VECS[i].eflag || match_addr !== VECS[i].eaddr) begin
            failures++;
            $display("FAIL R%0d vector %0d actual=%b/%0d expected=%b/%0d",
                     VECS[i].req, i, match_flag, match_addr, VECS[i].eflag, VECS[i].eaddr);
         end
      end

      // R10: results hold while inputs move without a strobe
      do_cmp(2'd3, 2'b00, 1'b0, 64'h0, KA);
      cmp_data = KB; cmp_type = 2'b10; cfg_cam_segs = 2'd0;
      repeat (2) @(negedge clk);
      chk("R10 flag held", 64'(match_flag), 64'd1);
      chk("R10 addr held", 64'(match_addr), 64'd0);

      // R8: write at hit address
      do_cmp(2'd3, 2'b00, 1'b0, 64'h0, KB);
      do_wr(2'b01, 4'd9, KD, 2'b00);
      do_rd(4'd1);
      chk("R8 write at hit address", rd_data, KD);

      // R8: write at free address, R9 free moves on
      do_wr(2'b10, 4'd9, KE, 2'b00);
      do_rd(4'd5);
      chk("R8 write at free address", rd_data, KE);
      chk("R9 free advances", 64'(free_addr), 64'd6);

      // R8: hit-address write after a miss changes nothing
      do_cmp(2'd3, 2'b00, 1'b0, 64'h0, 64'h1111_2222_3333_4445);
      do_wr(2'b01, 4'd9, KF, 2'b00);
      do_rd(4'd0);
      chk("R8 miss write leaves entry 0", rd_data, KA);
      do_rd(4'd9);
      chk("R8 miss write leaves entry 9 empty", 64'(rd_type), 64'd1);

      // R8: mode 11 writes nothing
      do_wr(2'b11, 4'd0, KF, 2'b00);
      do_rd(4'd0);
      chk("R8 mode 11 no write", rd_data, KA);

      // R9: fill the array
      for (int i = 6; i < 16; i++) do_wr(2'b10, 4'd0, 64'(i), 2'b10);
      chk("R9 full flag", 64'(full_flag), 64'd1);
      chk("R9 free zero when full", 64'(free_addr), 64'd0);

      // R8: free-address write while full changes nothing
      do_wr(2'b10, 4'd0, KF, 2'b00);
      do_rd(4'd0);
      chk("R8 full write leaves entry 0", rd_data, KA);

      // R9: absolute write freeing the last entry
      do_wr(2'b00, 4'd15, 64'h0, 2'b01);
      chk("R9 full clears", 64'(full_flag), 64'd0);
      chk("R9 free points at freed entry", 64'(free_addr), 64'd15);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule